// File: doc/BRIEF.md
# Oversampled serial receiver with line-error detection

This block turns a raw asynchronous serial line into bytes. The line is sampled only on an enable tick that runs at sixteen times the bit rate. A three-tick agreement filter removes short glitches. A framing state machine then finds the start bit, samples eight data bits least significant bit first, samples an optional parity bit and samples a single stop bit. Each of these bits is sampled at the middle of its bit period.

Each completed character produces a one-cycle valid strobe with the byte. A parity error and a frame error come out as pulses in the same cycle as the strobe. A separate counter tracks consecutive characters that are all-zero and have a missing stop bit. It raises a single break pulse when their number first goes above a programmable threshold.

The baud tick generator, receive buffering and any register access sit outside this block. All inputs are taken as synchronous to `clk_i`.

Top module: `uart_rx_core`

## Requirements
- R1: The filtered line (reset value 1) takes a new level only on a tick where the raw line has shown that level on that tick and on the two ticks before it. Otherwise it keeps its value, so a low pulse of one or two ticks never starts a character and never alters a data bit.
- R2: In idle, a low filtered line starts a character. On the 8th tick after the start, the start bit is checked again. If the filtered line is high there, the receiver returns to idle and emits nothing. When the line stays low after a frame error, the next character starts at once.
- R3: Every data, parity and stop bit is sampled on the 8th tick of its 16-tick period. There are 8 data bits, sent least significant bit first. When the stop bit is sampled, `rx_valid_o` pulses for one cycle and `rx_data_o` carries the byte.
- R4: When `parity_en_i` is 1, one parity bit follows the data bits. The expected parity bit is the XOR of the 8 data bits when `parity_odd_i` is 0, and its inverse when `parity_odd_i` is 1. A mismatch raises `parity_err_o` in the cycle of `rx_valid_o`. When `parity_en_i` is 0, no parity bit is expected and `parity_err_o` stays 0.
- R5: A stop bit sampled as 0 raises `frame_err_o` in the cycle of `rx_valid_o`. This holds with parity enabled and with parity disabled.
- R6: The block counts consecutive characters that have data 0x00 and a frame error. In the cycle after the `rx_valid_o` of the character that first makes this count larger than `break_thresh_i`, `break_o` pulses for one cycle. It pulses once per event, even while the line stays low.
- R7: Any character whose data is nonzero, or whose stop bit is 1, clears the break count.
- R8: During reset and after it, until a character completes, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Raw serial line, idle high |
| tick_i | input | 1 | Oversample enable, 16 per bit period |
| parity_en_i | input | 1 | Expect a parity bit after the data |
| parity_odd_i | input | 1 | 1 selects odd parity, 0 selects even |
| break_thresh_i | input | BRK_W | Number of break characters to exceed |
| rx_valid_o | output | 1 | One-cycle strobe for a received character |
| rx_data_o | output | DATA_W | Received byte |
| frame_err_o | output | 1 | Stop bit was 0 (valid with strobe) |
| parity_err_o | output | 1 | Parity mismatch (valid with strobe) |
| break_o | output | 1 | One-cycle break event pulse |

## Verification
The assertions check these properties on every cycle:
- The filtered line changes only on a tick, and only to the level the raw line had.
- The valid strobe and the break pulse each last one cycle.
- The error pulses never appear without the strobe.
- A break pulse always follows a zero character that had a frame error.

Only the bench scenarios can show the following:
- The correct byte is assembled, least significant bit first.
- Parity polarity is right for both settings.
- Two-tick glitches and a short false start leave no trace.
- The threshold is compared with "greater than".
- A good character clears the count.
- A line held low gives exactly one break.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;
endpackage

// File: rtl/uart_rx_filter.sv
module uart_rx_filter #(
  parameter int FILT_N = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic rx_i,
  output logic filt_o
);
  logic [FILT_N-2:0] hist_q;
  logic              all_hi, all_lo;

  assign all_hi = &{hist_q, rx_i};
  assign all_lo = ~|{hist_q, rx_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '1;
      filt_o <= 1'b1;
    end else if (tick_i) begin
      if (FILT_N > 2) hist_q <= {hist_q[FILT_N-3:0], rx_i};
      else            hist_q <= rx_i;
      if (all_hi)      filt_o <= 1'b1;
      else if (all_lo) filt_o <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
  import uart_rx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              line_i,
  input  logic              parity_en_i,
  input  logic              parity_odd_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              frame_err_o,
  output logic              parity_err_o
);
  localparam int CNT_W = $clog2(OVS);
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OVS/2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);
  localparam logic [BIT_W-1:0] TOP  = BIT_W'(DATA_W - 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BIT_W-1:0]  bit_q;
  logic [DATA_W-1:0] sh_q;
  logic              pbit_q;
  logic              at_mid, at_end;

  assign at_mid = tick_i && (cnt_q == MID);
  assign at_end = tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      cnt_q        <= '0;
      bit_q        <= '0;
      sh_q         <= '0;
      pbit_q       <= 1'b0;
      valid_o      <= 1'b0;
      data_o       <= '0;
      frame_err_o  <= 1'b0;
      parity_err_o <= 1'b0;
    end else begin
      valid_o      <= 1'b0;
      frame_err_o  <= 1'b0;
      parity_err_o <= 1'b0;
      if (tick_i) cnt_q <= at_end ? '0 : cnt_q + 1'b1;
      unique case (state_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (!line_i) state_q <= ST_START;
        end
        ST_START: begin
          if (at_mid && line_i) state_q <= ST_IDLE;
          else if (at_end) begin
            state_q <= ST_DATA;
            bit_q   <= '0;
          end
        end
        ST_DATA: begin
          if (at_mid) sh_q <= {line_i, sh_q[DATA_W-1:1]};
          if (at_end) begin
            if (bit_q == TOP) state_q <= parity_en_i ? ST_PAR : ST_STOP;
            else              bit_q   <= bit_q + 1'b1;
          end
        end
        ST_PAR: begin
          if (at_mid) pbit_q  <= line_i;
          if (at_end) state_q <= ST_STOP;
        end
        ST_STOP: begin
          if (at_mid) begin
            state_q      <= ST_IDLE;
            valid_o      <= 1'b1;
            data_o       <= sh_q;
            frame_err_o  <= !line_i;
            parity_err_o <= parity_en_i && (pbit_q != ((^sh_q) ^ parity_odd_i));
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_break.sv
module uart_rx_break #(
  parameter int DATA_W = 8,
  parameter int BRK_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              frame_err_i,
  input  logic [BRK_W-1:0]  thresh_i,
  output logic              break_o
);
  logic [BRK_W:0] cnt_q;
  logic           is_brk_char;

  assign is_brk_char = frame_err_i && (data_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      break_o <= 1'b0;
    end else begin
      break_o <= 1'b0;
      if (valid_i) begin
        if (is_brk_char) begin
          if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
          // fires only on the step that crosses the threshold
          break_o <= (cnt_q == {1'b0, thresh_i});
        end else begin
          cnt_q <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core #(
  parameter int OVS    = 16,
  parameter int DATA_W = 8,
  parameter int FILT_N = 3,
  parameter int BRK_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic              tick_i,
  input  logic              parity_en_i,
  input  logic              parity_odd_i,
  input  logic [BRK_W-1:0]  break_thresh_i,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              frame_err_o,
  output logic              parity_err_o,
  output logic              break_o
);
  logic filt_w;

  uart_rx_filter #(.FILT_N(FILT_N)) u_filt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .rx_i   (rx_i),
    .filt_o (filt_w)
  );

  uart_rx_framer #(.OVS(OVS), .DATA_W(DATA_W)) u_framer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .line_i       (filt_w),
    .parity_en_i  (parity_en_i),
    .parity_odd_i (parity_odd_i),
    .valid_o      (rx_valid_o),
    .data_o       (rx_data_o),
    .frame_err_o  (frame_err_o),
    .parity_err_o (parity_err_o)
  );

  uart_rx_break #(.DATA_W(DATA_W), .BRK_W(BRK_W)) u_brk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (rx_valid_o),
    .data_i      (rx_data_o),
    .frame_err_i (frame_err_o),
    .thresh_i    (break_thresh_i),
    .break_o     (break_o)
  );
endmodule

// File: rtl/uart_rx_checker.sv
module uart_rx_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              rx_i,
  input logic              filt,
  input logic              parity_en_i,
  input logic              rx_valid_o,
  input logic [DATA_W-1:0] rx_data_o,
  input logic              frame_err_o,
  input logic              parity_err_o,
  input logic              break_o
);
  p_filt_on_tick_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(filt));
  p_filt_follows_line_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(filt) |-> filt == $past(rx_i));
  p_valid_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);
  p_par_err_gated_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    parity_err_o |-> rx_valid_o && parity_en_i);
  p_frm_err_gated_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |-> rx_valid_o);
  p_brk_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    break_o |-> $past(rx_valid_o && frame_err_o && (rx_data_o == '0)));
  p_brk_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    break_o |=> !break_o);
endmodule

bind uart_rx_core uart_rx_checker #(.DATA_W(DATA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tick_i       (tick_i),
  .rx_i         (rx_i),
  .filt         (filt_w),
  .parity_en_i  (parity_en_i),
  .rx_valid_o   (rx_valid_o),
  .rx_data_o    (rx_data_o),
  .frame_err_o  (frame_err_o),
  .parity_err_o (parity_err_o),
  .break_o      (break_o)
);

// File: tb/tb_uart_rx_core.sv
`timescale 1ns/1ps
module tb_uart_rx_core;
  localparam int TICK_DIV = 4;
  localparam int NVEC     = 9;
  // {data[7:0], parity_en, odd, corrupt_parity, corrupt_stop}
  localparam logic [11:0] VEC [NVEC] = '{
    {8'h55, 4'b0000}, {8'hA3, 4'b1000}, {8'hA3, 4'b1100},
    {8'h00, 4'b1001}, {8'h3C, 4'b1010}, {8'h81, 4'b1110},
    {8'h7E, 4'b0001}, {8'hFF, 4'b1111}, {8'h01, 4'b0000}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic       tick = 1'b0;
  logic       pen = 1'b0, podd = 1'b0;
  logic [7:0] thresh = 8'hFF;
  logic       valid, fe, pe, brk;
  logic [7:0] data;
  int         tdiv = 0;
  int         nchk = 0, nfail = 0;
  int         nval = 0, nfe = 0, npe = 0, nbrk = 0;
  logic [7:0] cap_d = '0;
  logic       cap_fe = 1'b0, cap_pe = 1'b0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    tdiv <= (tdiv == TICK_DIV-1) ? 0 : tdiv + 1;
    tick <= (tdiv == TICK_DIV-1);
  end

  uart_rx_core dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .tick_i(tick),
    .parity_en_i(pen), .parity_odd_i(podd), .break_thresh_i(thresh),
    .rx_valid_o(valid), .rx_data_o(data), .frame_err_o(fe),
    .parity_err_o(pe), .break_o(brk)
  );

  always @(negedge clk) if (rst_n) begin
    if (valid) begin
      nval++; cap_d = data; cap_fe = fe; cap_pe = pe;
      if (fe) nfe++;
      if (pe) npe++;
    end
    if (brk) nbrk++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic lvl, input int nticks);
    rx = lvl;
    repeat (nticks*TICK_DIV) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit p_en, input bit odd,
                      input bit badp, input bit bads, input int glitch_bit);
    hold(1'b0, 16);
    for (int i = 0; i < 8; i++) begin
      if (i == glitch_bit) begin
        hold(d[i], 4); hold(1'b0, 2); hold(d[i], 10);
      end else hold(d[i], 16);
    end
    if (p_en) hold((^d) ^ odd ^ badp, 16);
    if (bads) begin hold(1'b0, 12); hold(1'b1, 4); end
    else hold(1'b1, 16);
    hold(1'b1, 32);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int v0, b0, f0;
    repeat (5) @(negedge clk);
    chk(!valid && !fe && !pe && !brk && data == 8'h00, "R8 reset outputs",
        {valid, fe, pe, brk}, 0);
    rst_n = 1'b1;
    hold(1'b1, 40);
    chk(!valid && !brk && nval == 0, "R8 idle after reset", nval, 0);

    // table of framed characters
    for (int i = 0; i < NVEC; i++) begin
      logic [7:0] d;
      logic       ep, ef;
      d = VEC[i][11:4];
      pen = VEC[i][3]; podd = VEC[i][2];
      ep = VEC[i][3] & VEC[i][1];
      ef = VEC[i][0];
      v0 = nval;
      send(d, VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0], -1);
      chk(nval == v0 + 1, "R3 one strobe per char", nval - v0, 1);
      chk(cap_d == d, "R3 data lsb first", cap_d, d);
      chk(cap_pe == ep, "R4 parity error", cap_pe, ep);
      chk(cap_fe == ef, "R5 frame error", cap_fe, ef);
    end
    pen = 1'b0; podd = 1'b0;

    // R1: two-tick glitch on idle line
    v0 = nval;
    hold(1'b0, 2); hold(1'b1, 200);
    chk(nval == v0, "R1 idle glitch ignored", nval - v0, 0);

    // R1: two-tick glitch inside a high data bit
    send(8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 3);
    chk(nval == v0 + 1 && cap_d == 8'hFF, "R1 mid-bit glitch", cap_d, 8'hFF);

    // R2: short low that fails the start re-check
    v0 = nval;
    hold(1'b0, 5); hold(1'b1, 200);
    chk(nval == v0, "R2 false start dropped", nval - v0, 0);
    send(8'h5A, 1'b0, 1'b0, 1'b0, 1'b0, -1);
    chk(nval == v0 + 1 && cap_d == 8'h5A, "R2 recovery after false start", cap_d, 8'h5A);

    // R7: good character clears the break count, threshold 1
    thresh = 8'd1;
    b0 = nbrk;
    send(8'h00, 1'b0, 1'b0, 1'b0, 1'b1, -1);
    send(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, -1);
    send(8'h00, 1'b0, 1'b0, 1'b0, 1'b1, -1);
    chk(nbrk == b0, "R7 count cleared by valid stop", nbrk - b0, 0);
    send(8'h00, 1'b0, 1'b0, 1'b0, 1'b1, -1);
    chk(nbrk == b0 + 1, "R6 break after exceeding 1", nbrk - b0, 1);
    send(8'h10, 1'b0, 1'b0, 1'b0, 1'b1, -1);
    send(8'h00, 1'b0, 1'b0, 1'b0, 1'b1, -1);
    chk(nbrk == b0 + 1, "R7 count cleared by nonzero data", nbrk - b0, 1);

    // R6: line held low, threshold 2, exactly one pulse
    thresh = 8'd2;
    b0 = nbrk; f0 = nfe; v0 = nval;
    hold(1'b0, 700); hold(1'b1, 300);
    chk(nfe == f0 + 4, "R2 back-to-back chars on low line", nfe - f0, 4);
    chk(nbrk == b0 + 1, "R6 single break per event", nbrk - b0, 1);
    chk(nval == v0 + 5, "R6 char count during break", nval - v0, 5);

    // R4: parity disabled never flags
    chk(npe == 3, "R4 total parity errors", npe, 3);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule